// File: doc/BRIEF.md
# Modem Line Status Watcher

This block watches four asynchronous modem handshake inputs from a serial port: carrier detect, ring, data set ready and clear to send. Each input is resynchronised into the core clock. Its present level is published in a status word. Each line also has a sticky flag that records a change on that line. For carrier detect, data set ready and clear to send, either edge sets the flag. For ring, only the trailing edge sets it, when the line goes from asserted to deasserted.

Software reads the status word to learn the levels and flags. It clears flags by writing ones to their positions. The word also holds one read/write flow-control mode bit, which this block stores but does not act on. When any flag goes from clear to set, the block emits a one-cycle change pulse toward the interrupt logic, where it feeds interrupt source bit 9.

Top module: `mdm_status_watch`

## Requirements
- R1: After reset the status word reads 0 and the change pulse is low.
- R2: Status bits 7..4 give the synchronised levels of carrier detect, ring, data set ready and clear to send, taken from `modem_in[3]`, `modem_in[2]`, `modem_in[1]` and `modem_in[0]` respectively. A level that changes before clock edge k appears on the status word after edge k+1.
- R3: Status bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) become set one cycle after a changed level of that line appears, on either edge direction.
- R4: Status bit 2 (ring) becomes set only when the synchronised ring level falls from 1 to 0. A rising ring level leaves it at 0.
- R5: When `wr_en` is high, a 1 in `wr_data[3:0]` clears the matching flag at that edge. A 0 leaves the flag as it is.
- R6: If a new edge on a line and a clearing write to its flag take effect at the same clock edge, the flag stays set.
- R7: `mdm_chg_evt` is high for exactly one cycle, in the same cycle as a flag becomes visible as set. A further edge on a line whose flag is already set gives no pulse.
- R8: Status bit 8 is a read/write mode bit loaded from `wr_data[8]` on every write. Write data in bits 7..4 has no effect on the reported levels.
- R9: Flags are sticky. They stay set after the line returns to its earlier level, until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| modem_in | input | 4 | Asynchronous modem lines: [3] carrier detect, [2] ring, [1] data set ready, [0] clear to send |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 9 | Write data: [8] mode bit, [3:0] write-one-to-clear flags |
| stat_rd | output | 9 | Status word: [8] mode, [7:4] levels, [3:0] change flags |
| mdm_chg_evt | output | 1 | One-cycle pulse when any flag newly sets |

## Verification
The bench builds the block with its default two-stage synchroniser. This fixes the input-to-level latency at two edges and the input-to-flag latency at three, so the exact cycle in which a clearing write collides with a newly detected edge can be targeted. The vector table steps through combinations of simultaneous multi-line changes, ring rising versus falling, and partial clears. Directed runs then probe the latency, the one-cycle width of the pulse, and the collision between a clear and an edge.

// File: rtl/mdm_stat_pkg.sv
package mdm_stat_pkg;

    localparam int LINE_CNT = 4;
    localparam int CTS_IDX  = 0;
    localparam int DSR_IDX  = 1;
    localparam int RING_IDX = 2;
    localparam int DCD_IDX  = 3;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    typedef struct packed {
        logic                fcm;
        logic [LINE_CNT-1:0] level;
        logic [LINE_CNT-1:0] flag;
    } stat_word_t;

    localparam int WORD_W = $bits(stat_word_t);

    function automatic edge_kind_e line_kind(int idx);
        return (idx == RING_IDX) ? EDGE_FALL : EDGE_ANY;
    endfunction

    function automatic logic edge_hit(edge_kind_e kind, logic prev, logic cur);
        if (kind == EDGE_FALL)
            return prev & ~cur;
        return prev ^ cur;
    endfunction

    function automatic logic [LINE_CNT-1:0] clear_mask(stat_word_t w);
        return w.flag;
    endfunction

    function automatic logic mode_bit(stat_word_t w);
        return w.fcm;
    endfunction

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            chain_q[0] <= '0;
        else
            chain_q[0] <= d_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain_q[s] <= '0;
            else
                chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_line_flag.sv
module mdm_line_flag
    import mdm_stat_pkg::*;
#(
    parameter edge_kind_e KIND = EDGE_ANY
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic clr,
    output logic flag,
    output logic newly_set
);

    logic prev_q;
    logic flag_q;
    logic hit;
    logic flag_d;

    always_comb begin
        hit       = edge_hit(KIND, prev_q, lvl);
        flag_d    = hit | (flag_q & ~clr);
        newly_set = flag_d & ~flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= lvl;
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    // R3: a flag only rises after a detected edge
    p_set_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(hit));

    // R5: clear without a competing edge drops the flag
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && clr && !hit) |=> !flag_q);

    // R6: an edge always leaves the flag set, clear or not
    p_edge_wins_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    // R9: without a clear the flag never drops
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/mdm_status_watch.sv
module mdm_status_watch
    import mdm_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_CNT-1:0] modem_in,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   stat_rd,
    output logic                mdm_chg_evt
);

    stat_word_t          wr_word;
    stat_word_t          stat_w;
    logic [LINE_CNT-1:0] lvl_sync;
    logic [LINE_CNT-1:0] flags;
    logic [LINE_CNT-1:0] newly;
    logic [LINE_CNT-1:0] clr_vec;
    logic                fcm_q;
    logic                evt_q;

    assign wr_word = stat_word_t'(wr_data);
    assign clr_vec = wr_en ? clear_mask(wr_word) : '0;

    mdm_sync #(
        .WIDTH  (LINE_CNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (modem_in),
        .q_sync  (lvl_sync)
    );

    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        mdm_line_flag #(
            .KIND (line_kind(i))
        ) u_flag (
            .clk       (clk),
            .rst       (rst),
            .lvl       (lvl_sync[i]),
            .clr       (clr_vec[i]),
            .flag      (flags[i]),
            .newly_set (newly[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcm_q <= 1'b0;
            evt_q <= 1'b0;
        end else begin
            if (wr_en)
                fcm_q <= mode_bit(wr_word);
            evt_q <= |newly;
        end
    end

    always_comb begin
        stat_w.fcm   = fcm_q;
        stat_w.level = lvl_sync;
        stat_w.flag  = flags;
    end

    assign stat_rd     = stat_w;
    assign mdm_chg_evt = evt_q;

    // R7: a pulse always comes with at least one set flag
    p_evt_has_flag_r7: assert property (@(posedge clk) disable iff (rst)
        mdm_chg_evt |-> (|flags));

    // R8: the mode bit follows the written value
    p_mode_rw_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (stat_rd[8] == $past(wr_data[8])));

    // R4: ring flag rises only after the level went 1 then 0
    p_ring_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[RING_IDX]) |-> (!$past(lvl_sync[RING_IDX]) && $past(lvl_sync[RING_IDX], 2)));

endmodule

// File: tb/test_mdm_status_watch.sv
module test_mdm_status_watch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] modem_in = 4'h0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = 9'h0;
    logic [8:0] stat_rd;
    logic       mdm_chg_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mdm_status_watch i_mdm_status_watch (
        .clk         (clk),
        .rst         (rst),
        .modem_in    (modem_in),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .stat_rd     (stat_rd),
        .mdm_chg_evt (mdm_chg_evt)
    );

    // {lines[3:0], clear[3:0], expected status[7:0], expected pulse}
    localparam logic [16:0] VEC [11] = '{
        {4'b0001, 4'b0000, 8'h11, 1'b1},  // R3 cts rise
        {4'b0000, 4'b0000, 8'h01, 1'b0},  // R9 sticky, R7 no repeat pulse
        {4'b0100, 4'b0001, 8'h40, 1'b0},  // R4 ring rise ignored, R5 clear
        {4'b0000, 4'b0000, 8'h04, 1'b1},  // R4 ring fall
        {4'b1010, 4'b0100, 8'hAA, 1'b1},  // R3 dcd+dsr rise
        {4'b1010, 4'b0010, 8'hA8, 1'b0},  // R5 partial clear
        {4'b1111, 4'b0000, 8'hF9, 1'b1},  // R3 cts, R4 ring rise
        {4'b1011, 4'b0000, 8'hBD, 1'b1},  // R4 ring fall
        {4'b1011, 4'b1111, 8'hB0, 1'b0},  // R5 clear all
        {4'b0000, 4'b0000, 8'h0B, 1'b1},  // R3 falling edges
        {4'b0000, 4'b1011, 8'h00, 1'b0}   // R5 clear
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 reset status", stat_rd, 9'h000);
        chk("R1 reset pulse", {8'h0, mdm_chg_evt}, 9'h000);

        // table walk
        for (int v = 0; v < 11; v++) begin
            int pulses;
            pulses   = 0;
            modem_in = VEC[v][16:13];
            wr_en    = (VEC[v][12:9] != 4'b0000);
            wr_data  = {5'b0, VEC[v][12:9]};
            tick();
            wr_en   = 1'b0;
            wr_data = 9'h0;
            if (mdm_chg_evt) pulses++;
            for (int c = 0; c < 4; c++) begin
                tick();
                if (mdm_chg_evt) pulses++;
            end
            chk($sformatf("R3/R4/R5 vector %0d status", v), stat_rd, {1'b0, VEC[v][8:1]});
            chk($sformatf("R7 vector %0d pulse count", v), 9'(pulses), {8'h0, VEC[v][0]});
        end

        // R8: mode bit writable, level bits not writable
        wr_en = 1'b1; wr_data = 9'h1F0;
        tick();
        wr_en = 1'b0; wr_data = 9'h0;
        chk("R8 mode set, levels untouched", stat_rd, 9'h100);
        wr_en = 1'b1; wr_data = 9'h000;
        tick();
        wr_en = 1'b0;
        chk("R8 mode cleared", stat_rd, 9'h000);

        // R2 / R3 / R7 latency of a dsr rise
        modem_in = 4'b0010;
        tick();
        chk("R2 level not yet after one edge", stat_rd, 9'h000);
        tick();
        chk("R2 level after two edges", stat_rd, 9'h020);
        chk("R7 no pulse before flag", {8'h0, mdm_chg_evt}, 9'h000);
        tick();
        chk("R3 flag one cycle after level", stat_rd, 9'h022);
        chk("R7 pulse with flag", {8'h0, mdm_chg_evt}, 9'h001);
        tick();
        chk("R7 pulse one cycle wide", {8'h0, mdm_chg_evt}, 9'h000);

        // R6: clear collides with a new edge on cts
        wr_en = 1'b1; wr_data = 9'h002;
        modem_in = 4'b0011;
        tick();
        wr_en = 1'b0; wr_data = 9'h0;
        repeat (4) tick();
        chk("R6 setup cts flag", stat_rd, 9'h031);
        modem_in = 4'b0010;
        tick();
        tick();
        wr_en = 1'b1; wr_data = 9'h001;
        tick();
        wr_en = 1'b0; wr_data = 9'h0;
        chk("R6 edge beats clear", stat_rd, 9'h021);
        chk("R6 no pulse on kept flag", {8'h0, mdm_chg_evt}, 9'h000);
        wr_en = 1'b1; wr_data = 9'h001;
        tick();
        wr_en = 1'b0; wr_data = 9'h0;
        chk("R5 later clear works", stat_rd, 9'h020);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule